// File: doc/BRIEF.md
# Upset-Tolerant Segmented Parity CAM

This block is a small binary content-addressable memory whose stored words survive clustered bit upsets. A data word of `SEGS*GROUPS` bits is viewed as `GROUPS` groups of `SEGS` consecutive bits. Each group gets one even-parity bit. The bits are then spread across physical segments so that segment `j` holds bit `j` of every group, and all group parities sit in one extra parity segment. An upset that stays inside one physical segment therefore flips at most one bit of any group.

A search encodes the key in the same way and compares it with each stored code word one segment at a time. A valid entry counts as matching when at most one segment disagrees. Any two distinct valid code words differ in at least two segments, so a clean table still gives exact answers. An entry that is corrupted within one segment still matches its original key. It may also match a few other keys that lie one segment away; this is accepted as a false positive. The result (hit, lowest matching index, multi-hit) is registered one cycle after the search strobe. A test port can XOR a mask into one segment of a stored entry without recomputing parity.

Top module: `seg_cam`

## Requirements
- R1: Encoding: data bit `g*SEGS+j` goes to bit `g` of segment `j`. Bit `g` of the parity segment is the XOR of data bits `g*SEGS` to `g*SEGS+SEGS-1`. Segment `s` occupies code bits `s*GROUPS` upward, and the parity segment has index `SEGS`. A written word is found again by a search with the same data.
- R2: After reset, every entry is invalid and `hit`, `hit_idx` and `multi_hit` are 0. A search then misses.
- R3: The result of a search appears on the outputs on the clock edge that samples `srch_en`=1. Without a strobe, the outputs hold their value.
- R4: A valid entry matches when zero or one of its `SEGS+1` segments differ from the encoded key. It does not match when two or more segments differ.
- R5: `hit_idx` is the lowest index among the matching entries.
- R6: `multi_hit` is 1 when two or more entries match. It implies `hit`.
- R7: Fault injection XORs `inj_mask` into segment `inj_seg` of entry `inj_idx` and leaves the other segments untouched. An entry corrupted only inside one segment still hits for its original key.
- R8: An entry corrupted in two different segments no longer matches its original key.
- R9: Take the default configuration, with segments written seg0, seg1, parity from left to right. Data 4'b1010 is stored as 00 11 11. If segment 0 is flipped to 11, the entry hits for keys 4'b1010, 4'b0101 (code 11 00 11) and 4'b1111 (code 11 11 00). It misses for 4'b0000.
- R10: A write stores a freshly encoded word and sets the entry valid. If a write and an injection target the same entry in the same cycle, the write wins. A search in the same cycle as a write sees the old contents.
- R11: Invalid entries never match. `hit_idx` is 0 when there is no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Entry to write |
| wr_data | input | DATA_W | Data to encode and store |
| inj_en | input | 1 | Test-only fault injection strobe |
| inj_idx | input | IDX_W | Entry to corrupt |
| inj_seg | input | SEG_W | Segment to corrupt (SEGS selects the parity segment) |
| inj_mask | input | GROUPS | Bits XORed into the selected segment |
| srch_en | input | 1 | Search strobe |
| srch_key | input | DATA_W | Search data |
| hit | output | 1 | Some valid entry matched |
| hit_idx | output | IDX_W | Lowest matching entry, 0 on miss |
| multi_hit | output | 1 | Two or more entries matched |

## Verification
The hardest state to reach from the ports is an entry whose stored code word is no longer a valid encoding. Writes always store clean code words, so corruption can only be produced through the injection port. The bench injects every mask into every segment of one entry, sweeps all keys against each corrupted table, and then undoes the fault with a second identical injection. It also builds two-segment corruptions to show the loss of the match. To prove that a write overrides an injection in the same cycle, it applies a second injection in another segment: a miss afterwards would show that the first injection had landed.

// File: rtl/seg_cam_pkg.sv
package seg_cam_pkg;
   localparam int unsigned SC_VEC_MAX = 64;

   // true when no more than one bit of v is set
   function automatic logic at_most_one(input logic [SC_VEC_MAX-1:0] v);
      return (v & (v - 64'd1)) == '0;
   endfunction
endpackage

// File: rtl/seg_cam_enc.sv
module seg_cam_enc #(
   parameter int unsigned GROUPS = 2,
   parameter int unsigned SEGS   = 2,
   localparam int unsigned DATA_W = GROUPS * SEGS,
   localparam int unsigned CODE_W = GROUPS * (SEGS + 1)
) (
   input  logic [DATA_W-1:0] data,
   output logic [CODE_W-1:0] code
);
   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      for (genvar j = 0; j < SEGS; j++) begin : g_bit
         assign code[j*GROUPS + g] = data[g*SEGS + j];
      end
      assign code[SEGS*GROUPS + g] = ^data[g*SEGS +: SEGS];
   end
endmodule

// File: rtl/seg_cam_row.sv
module seg_cam_row
   import seg_cam_pkg::*;
#(
   parameter int unsigned GROUPS = 2,
   parameter int unsigned SEGS   = 2,
   localparam int unsigned NSEG   = SEGS + 1,
   localparam int unsigned CODE_W = GROUPS * NSEG,
   localparam int unsigned SEG_W  = $clog2(NSEG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              inj_en,
   input  logic [SEG_W-1:0]  inj_seg,
   input  logic [GROUPS-1:0] inj_mask,
   input  logic [CODE_W-1:0] key_code,
   output logic              match,
   output logic              vld
);
   logic [CODE_W-1:0] code_q;
   logic [CODE_W-1:0] flip;
   logic [NSEG-1:0]   seg_diff;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      assign flip[s*GROUPS +: GROUPS] = (inj_seg == SEG_W'(s)) ? inj_mask : '0;
      assign seg_diff[s] = code_q[s*GROUPS +: GROUPS] != key_code[s*GROUPS +: GROUPS];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld    <= 1'b0;
         code_q <= '0;
      end else if (wr_en) begin
         vld    <= 1'b1;
         code_q <= wr_code;
      end else if (inj_en) begin
         code_q <= code_q ^ flip;
      end
   end

   assign match = vld & at_most_one(SC_VEC_MAX'(seg_diff));
endmodule

// File: rtl/seg_cam_pick.sv
module seg_cam_pick
   import seg_cam_pkg::*;
#(
   parameter int unsigned ENTRIES = 8,
   localparam int unsigned IDX_W = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0] match,
   output logic               any,
   output logic [IDX_W-1:0]   idx,
   output logic               multi
);
   always_comb begin
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match[i]) idx = IDX_W'(i);
      end
   end

   assign any   = |match;
   assign multi = any & ~at_most_one(SC_VEC_MAX'(match));
endmodule

// File: rtl/seg_cam.sv
module seg_cam
   import seg_cam_pkg::*;
#(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned GROUPS  = 2,
   parameter int unsigned SEGS    = 2,
   localparam int unsigned DATA_W = GROUPS * SEGS,
   localparam int unsigned CODE_W = GROUPS * (SEGS + 1),
   localparam int unsigned IDX_W  = $clog2(ENTRIES),
   localparam int unsigned SEG_W  = $clog2(SEGS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              inj_en,
   input  logic [IDX_W-1:0]  inj_idx,
   input  logic [SEG_W-1:0]  inj_seg,
   input  logic [GROUPS-1:0] inj_mask,
   input  logic              srch_en,
   input  logic [DATA_W-1:0] srch_key,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx,
   output logic              multi_hit
);
   if (ENTRIES < 2 || ENTRIES > SC_VEC_MAX) begin : g_bad_entries
      $error("seg_cam: ENTRIES must be in 2..64");
   end
   if (SEGS < 2 || SEGS + 1 > SC_VEC_MAX) begin : g_bad_segs
      $error("seg_cam: SEGS must be in 2..63");
   end
   if (GROUPS < 1) begin : g_bad_groups
      $error("seg_cam: GROUPS must be at least 1");
   end

   logic [CODE_W-1:0]  wr_code;
   logic [CODE_W-1:0]  key_code;
   logic [ENTRIES-1:0] row_match;
   logic [ENTRIES-1:0] vld;
   logic               any_c, multi_c;
   logic [IDX_W-1:0]   idx_c;

   seg_cam_enc #(.GROUPS(GROUPS), .SEGS(SEGS)) u_enc_wr (
      .data(wr_data), .code(wr_code)
   );
   seg_cam_enc #(.GROUPS(GROUPS), .SEGS(SEGS)) u_enc_key (
      .data(srch_key), .code(key_code)
   );

   for (genvar e = 0; e < ENTRIES; e++) begin : g_row
      seg_cam_row #(.GROUPS(GROUPS), .SEGS(SEGS)) u_row (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en  && wr_idx  == IDX_W'(e)),
         .wr_code  (wr_code),
         .inj_en   (inj_en && inj_idx == IDX_W'(e)),
         .inj_seg  (inj_seg),
         .inj_mask (inj_mask),
         .key_code (key_code),
         .match    (row_match[e]),
         .vld      (vld[e])
      );
   end

   seg_cam_pick #(.ENTRIES(ENTRIES)) u_pick (
      .match (row_match),
      .any   (any_c),
      .idx   (idx_c),
      .multi (multi_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit       <= 1'b0;
         hit_idx   <= '0;
         multi_hit <= 1'b0;
      end else if (srch_en) begin
         hit       <= any_c;
         hit_idx   <= idx_c;
         multi_hit <= multi_c;
      end
   end
endmodule

// File: rtl/seg_cam_chk.sv
module seg_cam_chk #(
   parameter int unsigned ENTRIES = 8,
   parameter int unsigned IDX_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               srch_en,
   input logic               wr_en,
   input logic [IDX_W-1:0]   wr_idx,
   input logic               hit,
   input logic [IDX_W-1:0]   hit_idx,
   input logic               multi_hit,
   input logic [ENTRIES-1:0] vld
);
   assert_multi_implies_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      multi_hit |-> hit);

   assert_miss_idx_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> hit_idx == '0);

   assert_hit_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> vld != '0);

   assert_hold_without_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !srch_en |=> $stable({hit, hit_idx, multi_hit}));

   assert_clean_after_reset_R2: assert property (@(posedge clk)
      !rst_n |=> !hit && !multi_hit && vld == '0);

   assert_write_sets_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> vld[$past(wr_idx)]);
endmodule

bind seg_cam seg_cam_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .srch_en   (srch_en),
   .wr_en     (wr_en),
   .wr_idx    (wr_idx),
   .hit       (hit),
   .hit_idx   (hit_idx),
   .multi_hit (multi_hit),
   .vld       (vld)
);

// File: tb/seg_cam_tb.sv
module seg_cam_tb;
   localparam int ENT = 8;
   localparam int M   = 2;
   localparam int S   = 2;
   localparam int DW  = M * S;
   localparam int CW  = M * (S + 1);
   localparam int IW  = 3;
   localparam int SW  = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [IW-1:0] wr_idx = '0;
   logic [DW-1:0] wr_data = '0;
   logic          inj_en = 1'b0;
   logic [IW-1:0] inj_idx = '0;
   logic [SW-1:0] inj_seg = '0;
   logic [M-1:0]  inj_mask = '0;
   logic          srch_en = 1'b0;
   logic [DW-1:0] srch_key = '0;
   logic          hit;
   logic [IW-1:0] hit_idx;
   logic          multi_hit;

   int n_chk = 0;
   int n_fail = 0;

   logic [CW-1:0] mdl_code [ENT];
   logic          mdl_vld  [ENT];
   logic          last_hit, last_multi;
   logic [IW-1:0] last_idx;

   always #10 clk = ~clk;

   seg_cam u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .inj_en(inj_en), .inj_idx(inj_idx), .inj_seg(inj_seg), .inj_mask(inj_mask),
      .srch_en(srch_en), .srch_key(srch_key),
      .hit(hit), .hit_idx(hit_idx), .multi_hit(multi_hit)
   );

   function automatic logic [CW-1:0] encode(input logic [DW-1:0] d);
      logic [CW-1:0] c = '0;
      for (int g = 0; g < M; g++)
         for (int j = 0; j < S; j++) begin
            c[j*M + g] = d[g*S + j];
            c[S*M + g] = c[S*M + g] ^ d[g*S + j];
         end
      return c;
   endfunction

   function automatic int seg_dist(input logic [CW-1:0] a, input logic [CW-1:0] b);
      int n = 0;
      for (int s = 0; s <= S; s++)
         if (a[s*M +: M] != b[s*M +: M]) n++;
      return n;
   endfunction

   task automatic expect_for(input logic [DW-1:0] key, output logic eh,
                             output logic [IW-1:0] ei, output logic em);
      int cnt = 0;
      eh = 1'b0; ei = '0; em = 1'b0;
      for (int e = ENT - 1; e >= 0; e--)
         if (mdl_vld[e] && seg_dist(mdl_code[e], encode(key)) <= 1) begin
            cnt++;
            ei = IW'(e);
         end
      eh = cnt > 0;
      em = cnt > 1;
   endtask

   task automatic check_out(input string tag, input logic eh, input logic [IW-1:0] ei,
                            input logic em);
      n_chk++;
      if (hit !== eh || hit_idx !== ei || multi_hit !== em) begin
         n_fail++;
         $display("FAIL %s: hit/idx/multi got %0b/%0d/%0b expected %0b/%0d/%0b",
                  tag, hit, hit_idx, multi_hit, eh, ei, em);
      end
   endtask

   task automatic do_search(input logic [DW-1:0] key, input string tag);
      logic eh, em;
      logic [IW-1:0] ei;
      expect_for(key, eh, ei, em);
      srch_en = 1'b1; srch_key = key;
      @(negedge clk);
      srch_en = 1'b0;
      check_out($sformatf("%s key=%h", tag, key), eh, ei, em);
      last_hit = eh; last_idx = ei; last_multi = em;
   endtask

   task automatic do_write(input int idx, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_idx = IW'(idx); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      mdl_code[idx] = encode(d);
      mdl_vld[idx] = 1'b1;
   endtask

   task automatic do_inj(input int idx, input int seg, input logic [M-1:0] mask);
      inj_en = 1'b1; inj_idx = IW'(idx); inj_seg = SW'(seg); inj_mask = mask;
      @(negedge clk);
      inj_en = 1'b0;
      mdl_code[idx][seg*M +: M] = mdl_code[idx][seg*M +: M] ^ mask;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int e = 0; e < ENT; e++) begin
         mdl_vld[e] = 1'b0;
         mdl_code[e] = '0;
      end
   endtask

   task automatic sweep(input string tag);
      for (int k = 0; k < (1 << DW); k++) do_search(DW'(k), tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic eh, em;
      logic [IW-1:0] ei;
      @(negedge clk);
      do_reset();
      // R2: outputs clear after reset, nothing stored
      check_out("R2 reset state", 1'b0, '0, 1'b0);
      sweep("R2 R11 empty table");

      // R1 R4: clean table with distinct words, exact matches only
      for (int e = 0; e < ENT; e++) do_write(e, DW'((e * 5 + 3) % 16));
      sweep("R1 R4 clean table");

      // R3: outputs hold without a strobe
      do_search(DW'(8), "R3 setup");
      repeat (3) @(negedge clk);
      check_out("R3 hold", last_hit, last_idx, last_multi);

      // R5 R6: duplicate word in entries 2 and 5
      do_write(5, DW'(13));
      do_search(DW'(13), "R5 R6 duplicate lowest index");
      do_write(5, DW'(12));

      // R7: every mask in every segment of entry 3, then undo
      for (int s = 0; s <= S; s++)
         for (int mk = 1; mk < (1 << M); mk++) begin
            do_inj(3, s, M'(mk));
            do_search(DW'(2), "R7 confined upset original key");
            sweep("R7 R4 corrupted table");
            do_inj(3, s, M'(mk));
         end

      // R9: worked false-positive case on a single entry
      do_reset();
      do_write(0, 4'b1010);
      do_inj(0, 0, 2'b11);
      do_search(4'b1010, "R9 original key");
      check_out("R9 original key hits", 1'b1, '0, 1'b0);
      do_search(4'b0101, "R9 false positive 110011");
      check_out("R9 key 0101 hits", 1'b1, '0, 1'b0);
      do_search(4'b1111, "R9 false positive 111100");
      check_out("R9 key 1111 hits", 1'b1, '0, 1'b0);
      do_search(4'b0000, "R9 far key");
      check_out("R9 key 0000 misses", 1'b0, '0, 1'b0);

      // R8: upset spanning two segments
      do_reset();
      do_write(0, 4'b1010);
      do_inj(0, 0, 2'b01);
      do_inj(0, 1, 2'b01);
      do_search(4'b1010, "R8 two-segment upset");
      check_out("R8 original key misses", 1'b0, '0, 1'b0);
      do_inj(0, 2, 2'b10);
      sweep("R8 R4 three-segment upset");

      // R10: search and write in the same cycle sees old contents
      do_reset();
      do_write(7, 4'b0110);
      expect_for(4'b1001, eh, ei, em);
      wr_en = 1'b1; wr_idx = 3'd7; wr_data = 4'b1001;
      srch_en = 1'b1; srch_key = 4'b1001;
      @(negedge clk);
      wr_en = 1'b0; srch_en = 1'b0;
      mdl_code[7] = encode(4'b1001);
      check_out("R10 search during write sees old word", eh, ei, em);
      do_search(4'b1001, "R10 new word visible");
      check_out("R10 new word hits entry 7", 1'b1, 3'd7, 1'b0);

      // R10: write beats a same-cycle injection on the same entry
      wr_en = 1'b1; wr_idx = 3'd6; wr_data = 4'b0011;
      inj_en = 1'b1; inj_idx = 3'd6; inj_seg = 2'd0; inj_mask = 2'b11;
      @(negedge clk);
      wr_en = 1'b0; inj_en = 1'b0;
      mdl_code[6] = encode(4'b0011);
      mdl_vld[6] = 1'b1;
      do_inj(6, 1, 2'b01);
      do_search(4'b0011, "R10 write overrides injection");
      check_out("R10 single later upset still hits", 1'b1, 3'd6, 1'b0);

      // R11: invalid entries stay silent
      do_search(4'b0000, "R11 untouched entries");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule